// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is a 32-bit timer that counts down at a rate set by an 8-bit prescale field. Software stores a start value and turns the timer on. The counter drops by one each time the prescale interval ends. The step from 1 to 0 is an expiry. An expiry sets a sticky status flag, which drives the interrupt output. Depending on a control bit, the counter then either refills from the stored start value or stays at zero.

Access is through a simple 32-bit register port. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. The port covers a 32-byte window of byte addresses, with four word registers at the bottom.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: Registers sit at byte offsets 0x0 (start value), 0x4 (counter), 0x8 (control) and 0xC (status). Address bits 1:0 are ignored. Offsets 0x10 to 0x1C read as 0. Control keeps only bit 0 (run), bit 1 (auto-refill) and bits 15:8 (prescale P), and every other control bit reads back as 0.
- R3: A write to 0x0 stores the value and also copies it into the counter. A write to 0x4 changes only the counter.
- R4: While enabled with a nonzero count, the counter steps down once every P+1 clocks. The first step comes P+1 clocks after the clock edge of a start-value write, a counter write or the enabling write.
- R5: The step from 1 to 0 sets status bit 0. With auto-refill off, the counter then stays at 0.
- R6: With auto-refill on, an expiry loads the counter from the start value in the same clock, and counting continues.
- R7: `irq_o` follows status bit 0. A write to 0xC clears status bit 0 when data bit 0 is 1, and leaves it unchanged when data bit 0 is 0.
- R8: If an expiry and a clearing status write land on the same edge, the status flag stays set.
- R9: A control write that turns run from 0 to 1 while the counter is 0 and the written auto-refill bit is 1 loads the counter from the start value.
- R10: Reading 0x4 returns 0 while run is off or the count is 0. The counter does not change while run is off.
- R11: An enabled timer whose counter is 0 neither counts nor sets status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt, equal to the status flag |

## Verification
Register writes are visible on the first edge after the strobe. The bench therefore drives each write on a falling edge and reads back on the following falling edge. Counter steps fall P+1 edges after the restarting write, and the bench waits an exact count of whole cycles, derived from P, before each counter or status sample. The collision case is timed so that the clearing write's edge is the same edge that takes the count from 1 to 0.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W      = 32;
  localparam int PSC_W       = 8;
  localparam int CTL_RUN_BIT = 0;
  localparam int CTL_RLD_BIT = 1;
  localparam int CTL_PSC_LSB = 8;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             refill;
    logic             run;
  } ctrl_t;

  // Unpack a written word into control fields.
  function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.run    = w[CTL_RUN_BIT];
    c.refill = w[CTL_RLD_BIT];
    c.psc    = w[CTL_PSC_LSB +: PSC_W];
    return c;
  endfunction

  // Pack control fields into the read-back word.
  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTL_RUN_BIT] = c.run;
    w[CTL_RLD_BIT] = c.refill;
    w[CTL_PSC_LSB +: PSC_W] = c.psc;
    return w;
  endfunction

  // Counter value after one step: 1 goes to refill-or-zero.
  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] cur,
                                                    input logic refill,
                                                    input logic [DATA_W-1:0] start);
    if (cur == DATA_W'(1)) return refill ? start : '0;
    return cur - DATA_W'(1);
  endfunction
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expiry,
  input  logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] start_q,
  output ctrl_t             ctrl_q,
  output logic              status_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              start_wr,
  output logic              count_wr,
  output logic              run_rise,
  output logic [PSC_W-1:0]  psc_restart_val
);
  localparam int SEL_LSB = 2;
  localparam int HI_LSB  = SEL_LSB + 2;

  logic     in_window;
  reg_sel_e sel;
  ctrl_t    ctrl_wr_val;
  logic     ctrl_wr;
  logic     stat_wr;

  assign in_window   = (bus_addr >> HI_LSB) == '0;
  assign sel         = reg_sel_e'(bus_addr[SEL_LSB +: 2]);
  assign ctrl_wr_val = ctrl_from_word(bus_wdata);

  assign start_wr = bus_wr && in_window && (sel == SEL_START);
  assign count_wr = bus_wr && in_window && (sel == SEL_COUNT);
  assign ctrl_wr  = bus_wr && in_window && (sel == SEL_CTRL);
  assign stat_wr  = bus_wr && in_window && (sel == SEL_STAT);
  assign run_rise = ctrl_wr && !ctrl_q.run && ctrl_wr_val.run;
  assign psc_restart_val = run_rise ? ctrl_wr_val.psc : ctrl_q.psc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      ctrl_q   <= '0;
      status_q <= 1'b0;
    end else begin
      if (start_wr) start_q <= bus_wdata;
      if (ctrl_wr)  ctrl_q  <= ctrl_wr_val;
      if (expiry)       status_q <= 1'b1;
      else if (stat_wr) status_q <= status_q & ~bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_window) begin
      unique case (sel)
        SEL_START: bus_rdata = start_q;
        SEL_COUNT: bus_rdata = (ctrl_q.run && count_q != '0) ? count_q : '0;
        SEL_CTRL:  bus_rdata = ctrl_to_word(ctrl_q);
        SEL_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, status_q};
      endcase
    end
  end

  p_expiry_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |=> status_q);
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[0] && !expiry) |=> !status_q);
  p_expiry_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && expiry) |=> status_q);
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [PSC_W-1:0] restart_val,
  input  logic [PSC_W-1:0] period_val,
  output logic             tick
);
  logic [PSC_W-1:0] psc_q;

  assign tick = active && !restart && (psc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psc_q <= '0;
    else if (restart) psc_q <= restart_val;
    else if (tick)    psc_q <= period_val;
    else if (active)  psc_q <= psc_q - PSC_W'(1);
  end

  p_restart_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> psc_q == $past(restart_val));
  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !restart) |=> $stable(psc_q));
endmodule

// File: rtl/timer_counter.sv
module timer_counter
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_any,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run_rise,
  input  logic              refill_new,
  input  logic              refill_cur,
  input  logic [DATA_W-1:0] start_q,
  input  logic              tick,
  input  logic              run,
  output logic [DATA_W-1:0] count_q,
  output logic              expiry
);
  logic arm_load;

  assign arm_load = run_rise && refill_new && (count_q == '0);
  assign expiry   = tick && (count_q == DATA_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (wr_any)   count_q <= wdata;
    else if (arm_load) count_q <= start_q;
    else if (tick)     count_q <= count_step(count_q, refill_cur, start_q);
  end

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q > DATA_W'(1)) |=> count_q == $past(count_q) - DATA_W'(1));
  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry && refill_cur) |=> count_q == $past(start_q));
  p_oneshot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expiry && !refill_cur) |=> count_q == '0);
  p_zero_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !wr_any && !arm_load) |=> count_q == '0);
  p_frozen_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_any && !arm_load) |=> $stable(count_q));
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] count_q;
  ctrl_t             ctrl_q;
  logic              status_q;
  logic              start_wr;
  logic              count_wr;
  logic              run_rise;
  logic [PSC_W-1:0]  psc_restart_val;
  logic              expiry;
  logic              tick;
  logic              active;
  logic              restart;

  assign active  = ctrl_q.run && (count_q != '0);
  assign restart = start_wr || count_wr || run_rise;
  assign irq_o   = status_q;

  timer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expiry(expiry), .count_q(count_q),
    .start_q(start_q), .ctrl_q(ctrl_q), .status_q(status_q),
    .bus_rdata(bus_rdata), .start_wr(start_wr), .count_wr(count_wr),
    .run_rise(run_rise), .psc_restart_val(psc_restart_val)
  );

  timer_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(restart),
    .restart_val(psc_restart_val), .period_val(ctrl_q.psc), .tick(tick)
  );

  timer_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_any(start_wr || count_wr),
    .wdata(bus_wdata), .run_rise(run_rise),
    .refill_new(bus_wdata[CTL_RLD_BIT]), .refill_cur(ctrl_q.refill),
    .start_q(start_q), .tick(tick), .run(ctrl_q.run),
    .count_q(count_q), .expiry(expiry)
  );

  p_no_tick_at_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |-> !tick);
  p_tick_needs_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_q.run);
endmodule

// File: tb/tb_tick_down_timer.sv
module tb_tick_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_down_timer #(.ADDR_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 16; a += 4) begin
      rd(5'(a), d);
      check("R1 reset read", d, 0);
    end
    check("R1 reset irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FF02);
    rd(5'h08, d); check("R2 control masked", d, 32'h0000_FF02);
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h1234_5678);
    rd(5'h02, d); check("R2 low bits ignored", d, 32'h1234_5678);
    rd(5'h10, d); check("R2 unmapped 0x10", d, 0);
    rd(5'h1C, d); check("R2 unmapped 0x1C", d, 0);
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h08, d); check("R2 write to unmapped ignored", d, 0);
  endtask

  task automatic t_load_vs_count;
    logic [31:0] d;
    wr(5'h00, 32'd7);
    rd(5'h04, d); check("R10 disabled count reads 0", d, 0);
    cyc(3);
    wr(5'h08, 32'h1);
    rd(5'h04, d); check("R3 load copied to counter, R10 held while off", d, 7);
    wr(5'h08, 32'h0);
    wr(5'h04, 32'd9);
    rd(5'h00, d); check("R3 counter write leaves start value", d, 7);
    wr(5'h08, 32'h1);
    rd(5'h04, d); check("R3 counter write value", d, 9);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    wr(5'h08, 32'h1);
    wr(5'h00, 32'd3);
    rd(5'h04, d); check("R4 count after load", d, 3);
    cyc(1); rd(5'h04, d); check("R4 P=0 step 1", d, 2);
    cyc(1); rd(5'h04, d); check("R4 P=0 step 2", d, 1);
    check("R7 irq low before expiry", {31'b0, irq_o}, 0);
    cyc(1); rd(5'h04, d); check("R5 oneshot zero", d, 0);
    rd(5'h0C, d); check("R5 status set", d, 1);
    check("R7 irq follows status", {31'b0, irq_o}, 1);
    cyc(4); rd(5'h0C, d); check("R5 stays expired", d, 1);
    wr(5'h0C, 32'hFFFF_FFFE);
    rd(5'h0C, d); check("R7 write 0 leaves status", d, 1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, d); check("R7 w1c clears status", d, 0);
    check("R7 irq low after clear", {31'b0, irq_o}, 0);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(5'h08, 32'h0000_0201);
    wr(5'h00, 32'd2);
    cyc(2); rd(5'h04, d); check("R4 P=2 no step before 3 clocks", d, 2);
    cyc(1); rd(5'h04, d); check("R4 P=2 first step", d, 1);
    cyc(2); rd(5'h04, d); check("R4 P=2 before second step", d, 1);
    check("R5 no status before expiry", {31'b0, irq_o}, 0);
    cyc(1); rd(5'h04, d); check("R4 P=2 second step", d, 0);
    rd(5'h0C, d); check("R5 P=2 expiry sets status", d, 1);
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_refill;
    logic [31:0] d;
    wr(5'h00, 32'd2);
    wr(5'h08, 32'h3);
    cyc(1); rd(5'h04, d); check("R6 step", d, 1);
    cyc(1); rd(5'h04, d); check("R6 refilled", d, 2);
    rd(5'h0C, d); check("R6 status on refill", d, 1);
    cyc(1); rd(5'h04, d); check("R6 keeps running", d, 1);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
  endtask

  task automatic t_rise_zero;
    logic [31:0] d;
    wr(5'h00, 32'd4);
    wr(5'h04, 32'd0);
    wr(5'h08, 32'h1);
    rd(5'h04, d); check("R10 zero count reads 0", d, 0);
    cyc(6);
    rd(5'h0C, d); check("R11 no expiry at zero", d, 0);
    wr(5'h08, 32'h0);
    wr(5'h08, 32'h3);
    rd(5'h04, d); check("R9 rise loads start value", d, 4);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    wr(5'h08, 32'h1);
    wr(5'h00, 32'd2);
    cyc(1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, d); check("R8 expiry beats clear", d, 1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, d); check("R8 later clear works", d, 0);
    wr(5'h08, 32'h0);
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_decode();
    t_load_vs_count();
    t_oneshot();
    t_prescale();
    t_refill();
    t_rise_zero();
    t_collision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule